// File: doc/BRIEF.md
# Address-Masked GPIO Port

An eight-pin general-purpose I/O port on a simple single-cycle register bus. Each pin has a direction bit and an output data bit. Software can change or sample any subset of the pins in a single access. The address of the data access picks the subset: the address bits act as a per-pin mask, so there is no read-modify-write sequence and no race between two agents that own different pins.

The block drives an output value and an output enable toward each pad. It samples the pad inputs through a two-flop synchronizer. A data read reports one value per pin. For a pin configured as an output, that value is the driven bit. For a pin configured as an input, it is the synchronized pad bit. Bits outside the address mask read as zero. The direction register holds a word at its own offset, above the data window. Every other offset does nothing.

Top module: `gpio_maskport`

## Requirements
- R1: After reset every pin is an input (`pad_oe` = 0x00), every output data bit is 0 (`pad_out` = 0x00) and `rdata` is 0x00.
- R2: A write to byte offset 0x400 loads the direction word. Bit n = 1 makes pin n an output, and `pad_oe` shows the new word on the cycle after the write.
- R3: A write to offsets 0x000–0x3FC updates output bit n only when address bit n+2 is 1. All other output bits keep their value.
- R4: In a data read, every bit whose address bit n+2 is 0 returns 0.
- R5: In a data read, an enabled bit n returns the output data bit when pin n is an output, and the synchronized pad bit when pin n is an input.
- R6: The output data bits are written and held regardless of direction, and `pad_out` always shows them. A value written while a pin is an input reaches the pad once the pin is made an output.
- R7: The pad inputs pass through two flops. A pad change made between two clock edges is not returned by reads strobed at the next two edges, and is returned by a read strobed at the third.
- R8: `rdata` is registered on the clock edge that samples `rd_en`. It holds its value on cycles without a read strobe.
- R9: Writes to offsets above 0x400 change neither `pad_out` nor `pad_oe`, and reads of those offsets return 0x00.
- R10: A read of offset 0x400 returns the current direction word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| addr | input | 11 | Byte address of the access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| pad_in | input | 8 | Asynchronous pad input levels |
| pad_out | output | 8 | Output data bits toward the pads |
| pad_oe | output | 8 | Per-pin output enable (the direction word) |

## Verification
The bench goes after partial masks. A design that ignored the address mask on writes would clobber neighbouring pins, and one that did not zero the unmasked read bits would leak other pins into single-pin reads. It mixes input and output pins in one read, which catches a read path that returns only the output register or only the pad. It counts the synchronizer latency edge by edge, so a single-flop or three-flop path returns the new pad value one read too early or too late. It writes data while pins are inputs and then flips the direction, and it writes to an unmapped offset. A design that gated the data register on direction, or decoded too few address bits, would show a wrong pad value or a changed enable.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

  localparam int PINS      = 8;
  localparam int ADDR_W    = 11;
  localparam int MASK_LSB  = 2;
  localparam int MASK_MSB  = MASK_LSB + PINS - 1;
  localparam int DIR_OFS   = 'h400;
  localparam int SYNC_DEPTH = 2;

  typedef logic [PINS-1:0]   pins_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {
    RG_DATA = 2'd0,
    RG_DIR  = 2'd1,
    RG_NONE = 2'd2
  } region_e;

  // Which register an address falls into.
  function automatic region_e region_of(addr_t a);
    addr_t dir_a;
    dir_a = addr_t'(DIR_OFS);
    if (a[ADDR_W-1:MASK_MSB+1] == '0)
      return RG_DATA;
    else if (a[ADDR_W-1:MASK_LSB] == dir_a[ADDR_W-1:MASK_LSB])
      return RG_DIR;
    else
      return RG_NONE;
  endfunction

  // Per-pin mask carried in the address.
  function automatic pins_t mask_of(addr_t a);
    return a[MASK_MSB:MASK_LSB];
  endfunction

  // Replace the bits of old_v selected by m with new_v.
  function automatic pins_t merge_masked(pins_t old_v, pins_t new_v, pins_t m);
    return (old_v & ~m) | (new_v & m);
  endfunction

  // Per-pin observed level: driven value for outputs, pad for inputs.
  function automatic pins_t pin_view(pins_t dir, pins_t drv, pins_t pad);
    return (dir & drv) | (~dir & pad);
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
  import gpio_mask_pkg::*;
#(
  parameter int WIDTH = PINS,
  parameter int DEPTH = SYNC_DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[0] <= '0;
        else        stage[0] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[s] <= '0;
        else        stage[s] <= stage[s-1];
      end
    end
  end

  assign sync_out = stage[DEPTH-1];

endmodule

// File: rtl/gpio_dir_reg.sv
module gpio_dir_reg
  import gpio_mask_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  pins_t wdata,
  output pins_t dir_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dir_q <= '0;
    else if (load) dir_q <= wdata;
  end

endmodule

// File: rtl/gpio_out_reg.sv
module gpio_out_reg
  import gpio_mask_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  pins_t mask,
  input  pins_t wdata,
  output pins_t out_q
);

  pins_t out_d;

  always_comb out_d = load ? merge_masked(out_q, wdata, mask) : out_q;

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q[p] <= 1'b0;
      else        out_q[p] <= out_d[p];
    end
  end

endmodule

// File: rtl/gpio_rd_path.sv
module gpio_rd_path
  import gpio_mask_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rd_en,
  input  region_e region,
  input  pins_t mask,
  input  pins_t dir_q,
  input  pins_t out_q,
  input  pins_t pad_sync,
  output pins_t rdata
);

  pins_t rd_next;

  always_comb begin
    unique case (region)
      RG_DATA: rd_next = pin_view(dir_q, out_q, pad_sync) & mask;
      RG_DIR:  rd_next = dir_q;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end

endmodule

// File: rtl/gpio_maskport.sv
module gpio_maskport
  import gpio_mask_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [10:0] addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic [7:0]  pad_in,
  output logic [7:0]  pad_out,
  output logic [7:0]  pad_oe
);

  // Named decode events, visible to the checker.
  region_e acc_region;
  pins_t   acc_mask;
  logic    wr_data_hit;
  logic    wr_dir_hit;
  pins_t   dir_q;
  pins_t   out_q;
  pins_t   pad_sync;

  assign acc_region  = region_of(addr);
  assign acc_mask    = mask_of(addr);
  assign wr_data_hit = wr_en && (acc_region == RG_DATA);
  assign wr_dir_hit  = wr_en && (acc_region == RG_DIR);

  gpio_in_sync #(.WIDTH(PINS), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (pad_sync)
  );

  gpio_dir_reg u_dir (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (wr_dir_hit),
    .wdata (wdata),
    .dir_q (dir_q)
  );

  gpio_out_reg u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (wr_data_hit),
    .mask  (acc_mask),
    .wdata (wdata),
    .out_q (out_q)
  );

  gpio_rd_path u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .region   (acc_region),
    .mask     (acc_mask),
    .dir_q    (dir_q),
    .out_q    (out_q),
    .pad_sync (pad_sync),
    .rdata    (rdata)
  );

  assign pad_out = out_q;
  assign pad_oe  = dir_q;

endmodule

// File: rtl/gpio_maskport_chk.sv
module gpio_maskport_chk
  import gpio_mask_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [10:0] addr,
  input logic [7:0]  wdata,
  input logic [7:0]  rdata,
  input logic [7:0]  pad_out,
  input logic [7:0]  pad_oe,
  input logic        wr_data_hit,
  input logic        wr_dir_hit,
  input logic [7:0]  acc_mask,
  input region_e     acc_region
);

  a_r2_oe_follows_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir_hit |=> pad_oe == $past(wdata));

  a_r3_masked_bits_written: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_hit |=> (pad_out & $past(acc_mask)) == ($past(wdata) & $past(acc_mask)));

  a_r3_unmasked_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_hit |=> (pad_out & ~$past(acc_mask)) == ($past(pad_out) & ~$past(acc_mask)));

  a_r4_unmasked_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && acc_region == RG_DATA) |=> (rdata & ~$past(acc_mask)) == 8'h00);

  a_r8_rdata_held: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  a_r9_unmapped_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && acc_region == RG_NONE) |=> ($stable(pad_out) && $stable(pad_oe)));

  a_r9_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && acc_region == RG_NONE) |=> rdata == 8'h00);

  a_r10_dir_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && acc_region == RG_DIR && !wr_en) |=> rdata == $past(pad_oe));

endmodule

bind gpio_maskport gpio_maskport_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .addr        (addr),
  .wdata       (wdata),
  .rdata       (rdata),
  .pad_out     (pad_out),
  .pad_oe      (pad_oe),
  .wr_data_hit (wr_data_hit),
  .wr_dir_hit  (wr_dir_hit),
  .acc_mask    (acc_mask),
  .acc_region  (acc_region)
);

// File: tb/gpio_maskport_test.sv
module gpio_maskport_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  // op: 0 write, 1 read and compare rdata, 2 compare pad_out, 3 compare pad_oe
  typedef struct packed {
    logic [1:0]  op;
    logic [10:0] adr;
    logic [7:0]  val;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  // pad_in is held at 0xA5 for the whole table.
  localparam vec_t VEC [NV] = '{
    '{2'd1, 11'h400, 8'h00, 4'd10}, // R10 dir reads zero after reset
    '{2'd0, 11'h3FC, 8'h3C, 4'd3},  // full-mask write
    '{2'd2, 11'h000, 8'h3C, 4'd3},
    '{2'd0, 11'h03C, 8'hFF, 4'd3},  // mask 0x0F
    '{2'd2, 11'h000, 8'h3F, 4'd3},  // R3 upper nibble kept
    '{2'd0, 11'h008, 8'h00, 4'd3},  // single pin 1 cleared
    '{2'd2, 11'h000, 8'h3D, 4'd3},
    '{2'd0, 11'h400, 8'hF0, 4'd2},  // dir: upper outputs
    '{2'd3, 11'h000, 8'hF0, 4'd2},  // R2
    '{2'd1, 11'h3FC, 8'h35, 4'd5},  // R5 mixed view
    '{2'd1, 11'h040, 8'h10, 4'd4},  // R4 pin 4 only
    '{2'd1, 11'h004, 8'h01, 4'd4},  // pad pin 0 high
    '{2'd1, 11'h008, 8'h00, 4'd4},  // pad pin 1 low
    '{2'd0, 11'h404, 8'hFF, 4'd9},  // unmapped write
    '{2'd3, 11'h000, 8'hF0, 4'd9},  // R9 oe unchanged
    '{2'd2, 11'h000, 8'h3D, 4'd9},  // R9 out unchanged
    '{2'd1, 11'h404, 8'h00, 4'd9},  // R9 unmapped read
    '{2'd1, 11'h400, 8'hF0, 4'd10}, // R10
    '{2'd0, 11'h400, 8'h00, 4'd6},  // all inputs
    '{2'd0, 11'h3FC, 8'h81, 4'd6},  // write while inputs
    '{2'd2, 11'h000, 8'h81, 4'd6},  // R6 held on pad_out
    '{2'd1, 11'h3FC, 8'hA5, 4'd5}   // inputs read pad
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [10:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [7:0]  pad_in = 8'hA5;
  logic [7:0]  pad_out;
  logic [7:0]  pad_oe;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_maskport uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string rq, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", rq, act, exp);
    end
  endtask

  task automatic do_write(input logic [10:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [10:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  initial begin
    logic [7:0] got;
    logic [7:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 pad_out", pad_out, 8'h00);
    check("R1 rdata", rdata, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      case (VEC[i].op)
        2'd0: do_write(VEC[i].adr, VEC[i].val);
        2'd1: begin do_read(VEC[i].adr, got); check(tag, got, VEC[i].val); end
        2'd2: check(tag, pad_out, VEC[i].val);
        default: check(tag, pad_oe, VEC[i].val);
      endcase
    end

    // R6: pending value appears on the pads once made outputs
    do_write(11'h400, 8'hFF);
    check("R6 oe", pad_oe, 8'hFF);
    do_read(11'h3FC, got);
    check("R6 readback", got, 8'h81);

    // R7: two-flop latency, pins as inputs
    do_write(11'h400, 8'h00);
    pad_in = 8'h00;
    repeat (3) @(negedge clk);
    pad_in = 8'hFF;
    do_read(11'h3FC, got);
    check("R7 edge1", got, 8'h00);
    do_read(11'h3FC, got);
    check("R7 edge2", got, 8'h00);
    do_read(11'h3FC, got);
    check("R7 edge3", got, 8'hFF);

    // R8: rdata holds without a strobe
    held = rdata;
    pad_in = 8'h00;
    addr = 11'h400;
    repeat (4) @(negedge clk);
    check("R8 hold", rdata, held);

    // R4: empty mask reads zero even with pins high
    pad_in = 8'hFF;
    repeat (3) @(negedge clk);
    do_read(11'h000, got);
    check("R4 empty mask", got, 8'h00);

    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule